// File: doc/BRIEF.md
# Signed Doubleword Divide Unit

This block is the integer divide engine of a RISC execution pipe. It divides a signed operand A by a signed operand B. The quotient truncates toward zero. Only the quotient is produced; no remainder leaves the block. The unit also applies the architected status side effects of the divide: it updates an overflow flag and a sticky summary-overflow flag, and it can produce a 4-bit condition field from the result.

A one-cycle `start` pulse captures the operands, the overflow-enable and record bits, and the current overflow and summary-overflow flag values. The datapath takes the magnitudes of both operands and runs a radix-2 restoring divide, one quotient bit per cycle. It negates the quotient when the operand signs differ. Two operand pairs have no defined quotient: a zero divisor, and the most negative value divided by minus one. Both are caught in the start cycle and skip the loop. They yield a zero quotient and never trap. The unit takes one operation at a time and holds `busy` until a one-cycle `done` pulse.

The controller has three states. IDLE waits for `start`. CALC runs the iterations. DONE presents the results for one cycle. The transitions are:
- IDLE→CALC on `start` with defined operands.
- IDLE→DONE on `start` with an undefined pair.
- CALC→CALC while iterations remain.
- CALC→DONE after the last iteration.
- DONE→IDLE unconditionally.
- IDLE→IDLE without `start`.

Top module: `sdiv_unit`

## Requirements
- R1: For defined operands, `quot` at `done` equals A divided by B as signed DATA_W-bit two's-complement values, truncated toward zero.
- R2: When B is zero, `quot` is 0 and `done` rises in the cycle right after the start cycle, with no trap or other signal.
- R3: When A is the most negative value and B is all ones (−1), `quot` is 0 and `done` rises in the cycle right after the start cycle.
- R4: With overflow-enable set, `ov_out` is 1 exactly when R2 or R3 applies and 0 otherwise. `so_out` is the captured `so_in` ORed with that overflow value.
- R5: With overflow-enable clear, `ov_out` and `so_out` equal the `ov_in` and `so_in` values captured at start.
- R6: `cr_out` is {LT, GT, EQ, SO} in bits 3 down to 0. LT, GT and EQ come from a signed compare of the full quotient with zero. SO equals the updated `so_out` of the same operation.
- R7: During `done`, `cr_valid` equals the record bit captured at start.
- R8: For defined operands, `done` comes exactly DATA_W+1 cycles after the start cycle. `busy` is high from the cycle after start up to and including the `done` cycle, and low again the cycle after.
- R9: A `start` pulse while `busy` is high is ignored. The operation in flight completes with its own operands.
- R10: `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; captured only when not busy |
| op_a | input | DATA_W | Dividend (signed) |
| op_b | input | DATA_W | Divisor (signed) |
| oe | input | 1 | Overflow-enable bit of the operation |
| rc | input | 1 | Record bit: request a condition field |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current summary-overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quot | output | DATA_W | Quotient, valid with `done` |
| ov_out | output | 1 | New overflow flag, valid with `done` |
| so_out | output | 1 | New summary-overflow flag, valid with `done` |
| cr_out | output | 4 | Condition field {LT,GT,EQ,SO}, valid with `done` |
| cr_valid | output | 1 | Condition field should be written back |

## Verification
The overflow update and the condition-field production both resolve in the `done` cycle. The SO bit of the field must already carry the overflow raised by the same divide. This case is provoked with an undefined operand pair, overflow-enable and record both set, and `so_in` low. It is judged by requiring `cr_out[0]` to be 1 and to match `so_out`. A second coincidence, a fresh `start` arriving while a divide is in flight, is driven one cycle after acceptance with different operands. The result is checked against the first operand pair and the expected latency.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DONE
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_special.sv
// Flags the two operand pairs whose quotient is undefined.
module sdiv_special #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         special
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    logic zero_div;
    logic min_neg;
    always_comb begin
        zero_div = (b == '0);
        min_neg  = (a == MOST_NEG) && (b == '1);
        special  = zero_div || min_neg;
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring-divide iteration on magnitudes.
module sdiv_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] dvd_nx
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       qbit;
    always_comb begin
        shifted = {rem, dvd[W-1]};
        diff    = shifted - {1'b0, dvs};
        qbit    = ~diff[W];
        rem_nx  = qbit ? diff[W-1:0] : shifted[W-1:0];
        dvd_nx  = {dvd[W-2:0], qbit};
    end
endmodule

// File: rtl/sdiv_flags.sv
// Overflow/summary-overflow update and condition field.
module sdiv_flags #(
    parameter int W = 64
) (
    input  logic [W-1:0] quot,
    input  logic         oe,
    input  logic         special,
    input  logic         ov_in,
    input  logic         so_in,
    output logic         ov_out,
    output logic         so_out,
    output logic [3:0]   cr_out
);
    logic lt, gt, eq;
    always_comb begin
        ov_out = oe ? special : ov_in;
        so_out = oe ? (so_in | special) : so_in;
        eq     = (quot == '0);
        lt     = quot[W-1];
        gt     = ~lt & ~eq;
        cr_out = {lt, gt, eq, so_out};
    end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              oe,
    input  logic              rc,
    input  logic              ov_in,
    input  logic              so_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quot,
    output logic              ov_out,
    output logic              so_out,
    output logic [3:0]        cr_out,
    output logic              cr_valid
);
    import sdiv_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    sdiv_state_e         state;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   rem_q, dvd_q, dvs_q;
    logic                neg_q, spec_q, oe_q, rc_q, ov_q, so_q;

    logic                spec_in;
    logic [DATA_W-1:0]   a_mag, b_mag;
    logic [DATA_W-1:0]   rem_nx, dvd_nx;
    logic [DATA_W-1:0]   quot_int;
    logic                accept;

    sdiv_special #(.W(DATA_W)) special_i (
        .a       (op_a),
        .b       (op_b),
        .special (spec_in)
    );

    sdiv_step #(.W(DATA_W)) step_i (
        .rem    (rem_q),
        .dvd    (dvd_q),
        .dvs    (dvs_q),
        .rem_nx (rem_nx),
        .dvd_nx (dvd_nx)
    );

    always_comb begin
        a_mag  = op_a[DATA_W-1] ? (~op_a + 1'b1) : op_a;
        b_mag  = op_b[DATA_W-1] ? (~op_b + 1'b1) : op_b;
        accept = start && (state == ST_IDLE);
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
            neg_q  <= 1'b0;
            spec_q <= 1'b0;
            oe_q   <= 1'b0;
            rc_q   <= 1'b0;
            ov_q   <= 1'b0;
            so_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        rem_q  <= '0;
                        dvd_q  <= a_mag;
                        dvs_q  <= b_mag;
                        neg_q  <= op_a[DATA_W-1] ^ op_b[DATA_W-1];
                        spec_q <= spec_in;
                        oe_q   <= oe;
                        rc_q   <= rc;
                        ov_q   <= ov_in;
                        so_q   <= so_in;
                        cnt    <= '0;
                        state  <= spec_in ? ST_DONE : ST_CALC;
                    end
                end
                ST_CALC: begin
                    rem_q <= rem_nx;
                    dvd_q <= dvd_nx;
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        quot_int = spec_q ? '0 : (neg_q ? (~dvd_q + 1'b1) : dvd_q);
        quot     = quot_int;
        cr_valid = done && rc_q;
    end

    sdiv_flags #(.W(DATA_W)) flags_i (
        .quot    (quot_int),
        .oe      (oe_q),
        .special (spec_q),
        .ov_in   (ov_q),
        .so_in   (so_q),
        .ov_out  (ov_out),
        .so_out  (so_out),
        .cr_out  (cr_out)
    );
endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] quot,
    input logic [3:0]        cr_out
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_b == '0) |=> (done && quot == '0));

    p_min_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_a == MOST_NEG && op_b == '1) |=> (done && quot == '0));

    p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(cr_out[3:1]) == 1 && cr_out[1] == (quot == '0)));
endmodule

bind sdiv_unit sdiv_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (busy),
    .done   (done),
    .quot   (quot),
    .cr_out (cr_out)
);

// File: tb/sdiv_unit_tb_top.sv
module sdiv_unit_tb_top;
    localparam int W      = 6;
    localparam int CLK_NS = 10;
    localparam int HALF   = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         oe = 1'b0, rc = 1'b0, ov_in = 1'b0, so_in = 1'b0;
    logic         busy, done, ov_out, so_out, cr_valid;
    logic [W-1:0] quot;
    logic [3:0]   cr_out;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_NS/2) clk = ~clk;

    sdiv_unit #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .oe(oe), .rc(rc), .ov_in(ov_in), .so_in(so_in),
        .busy(busy), .done(done), .quot(quot), .ov_out(ov_out),
        .so_out(so_out), .cr_out(cr_out), .cr_valid(cr_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input int a, input int b, input bit e_oe, input bit e_rc,
                          input bit e_ov, input bit e_so, input bit inject);
        bit           spec;
        int           q;
        logic [W-1:0] qe;
        bit           x_ov, x_so;
        logic [3:0]   x_cr;
        int           lat;
        int           x_lat;
        spec  = (b == 0) || (a == -HALF && b == -1);
        q     = spec ? 0 : a / b;
        qe    = q[W-1:0];
        x_ov  = e_oe ? spec : e_ov;
        x_so  = e_oe ? (e_so | spec) : e_so;
        x_cr  = {qe[W-1], (!qe[W-1] && qe != 0), (qe == 0), x_so};
        x_lat = spec ? 1 : W + 1;

        @(negedge clk);
        start = 1'b1; op_a = a[W-1:0]; op_b = b[W-1:0];
        oe = e_oe; rc = e_rc; ov_in = e_ov; so_in = e_so;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (inject && !done) begin
            // R9: foreign request while busy
            start = 1'b1; op_a = ~op_a; op_b = 6'd1;
            oe = ~oe; rc = ~rc; ov_in = ~ov_in; so_in = ~so_in;
        end
        while (!done && lat < W + 10) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (!done) check(busy, "R8 busy", busy, 1);
        end
        check(lat == x_lat, spec ? "R2/R3 latency" : "R8 latency", lat, x_lat);
        check(quot == qe, spec ? "R2/R3 quotient" : "R1 quotient", int'(quot), int'(qe));
        check(ov_out == x_ov, e_oe ? "R4 ov" : "R5 ov", ov_out, x_ov);
        check(so_out == x_so, e_oe ? "R4 so" : "R5 so", so_out, x_so);
        check(cr_valid == e_rc, "R7 cr_valid", cr_valid, e_rc);
        check(cr_out == x_cr, "R6 cr", cr_out, x_cr);
        @(negedge clk);
        check(!done && !busy, "R10 done pulse", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done, "reset idle", {busy, done}, 0);
        rst_n = 1'b1;
        // Same-cycle overflow + SO in condition field (R3, R4, R6)
        run_op(-HALF, -1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_op(7, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int a = -HALF; a < HALF; a++) begin
            for (int b = -HALF; b < HALF; b++) begin
                int idx;
                idx = (a + HALF) * 2 * HALF + (b + HALF);
                run_op(a, b, idx[0], idx[1] ^ idx[3], idx[2], idx[4] ^ idx[0],
                       (idx % 7) == 3);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 190000);
        errors++;
        vectors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule